// File: doc/BRIEF.md
# Microsecond Compare-Match Timer

This block keeps a free-running 64-bit timestamp that advances once per microsecond. The tick comes from a prescaler that divides the core clock, whose frequency in MHz is a parameter. The count starts from its reset value as soon as reset is released and needs no setup. Software reaches the block through a 32-bit register port with a valid/ready handshake. It reads the timestamp as two words and programs a 64-bit compare target.

When comparison is enabled and the timestamp has reached or passed the target, the block latches a match flag. It drives a level interrupt for as long as the flag is set and comparison stays enabled. Software clears the flag by writing one to it. The enable bit sits behind a companion write-enable bit in the same register, so a control write that leaves the companion bit low does not change the enable.

Top module: `usec_match_timer`

## Requirements
- R1: After reset the timestamp equals the RESET_COUNT parameter, the compare words read 0, control and status read 0, `irq` is 0, `bus_rvalid` is 0.
- R2: The timestamp rises by exactly one after every CORE_MHZ clock cycles following reset, and wraps from 2^64-1 to 0.
- R3: A read of offset 0x00 returns timestamp bits 31:0 and captures bits 63:32 in the same cycle. A read of offset 0x04 returns that captured value, even if the timestamp has carried into its upper word since then.
- R4: Offsets 0x08 and 0x0C hold compare bits 31:0 and 63:32. Both are writable and read back what was written.
- R5: At offset 0x10, bit 0 is the compare enable and bit 1 is its write-enable. A write updates bit 0 only when bit 1 of the written data is 1. Reads return the enable in bit 0 and 0 in every other bit.
- R6: While the enable is 1 and the timestamp is greater than or equal to the compare value, status bit 0 at offset 0x14 becomes 1 on the following clock edge. It does not become 1 earlier.
- R7: The status flag stays 1 until software writes 1 to bit 0 of offset 0x14. Writing 0 has no effect, and disabling the compare does not clear the flag.
- R8: `irq` is 1 exactly when the status flag is 1 and the compare enable is 1.
- R9: When a clear write and a match fall in the same cycle, the flag stays 1.
- R10: Reads of offsets other than the six mapped ones return 0, and writes to them change nothing. Writes to 0x00 and 0x04 are ignored.
- R11: `bus_ready` is always 1. An accepted read returns its data on `bus_rdata` with `bus_rvalid` high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_ready | output | 1 | Access accepted (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read is accepted |
| irq | output | 1 | Level compare-match interrupt |

## Verification
A clear of the status flag can land in the same cycle as a live match. The bench provokes this by writing one to the status bit while comparison is still enabled and the timestamp is past the target. It then reads the status back as 1 and sees `irq` still high. In a second overlap, a low-word read captures the upper word a few ticks before a carry ripples into it. The later high-word read must return the pre-carry upper word, not the live one. The cycle in which the flag sets is checked against a timestamp model that the bench keeps from its own edge count.

// File: rtl/usec_tmr_pkg.sv
package usec_tmr_pkg;

    localparam int WORD_W = 32;
    localparam int TS_W   = 64;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_WEN_BIT = 1;
    localparam int STAT_HIT_BIT = 0;

    typedef enum logic [2:0] {
        SEL_TS_LO  = 3'd0,
        SEL_TS_HI  = 3'd1,
        SEL_CMP_LO = 3'd2,
        SEL_CMP_HI = 3'd3,
        SEL_CTRL   = 3'd4,
        SEL_STAT   = 3'd5,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } bus_op_t;

    // Word-aligned offsets 0x00..0x14 map to registers; anything else is a hole.
    function automatic reg_sel_e decode_offset(input logic [31:0] a);
        reg_sel_e s;
        s = SEL_NONE;
        if (a[1:0] == 2'b00) begin
            case (a[31:2])
                30'd0:   s = SEL_TS_LO;
                30'd1:   s = SEL_TS_HI;
                30'd2:   s = SEL_CMP_LO;
                30'd3:   s = SEL_CMP_HI;
                30'd4:   s = SEL_CTRL;
                30'd5:   s = SEL_STAT;
                default: s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/utmr_prescaler.sv
module utmr_prescaler #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PC_W = $clog2(DIV);
            localparam logic [PC_W-1:0] LAST = PC_W'(DIV - 1);
            logic [PC_W-1:0] pc;

            always_ff @(posedge clk) begin
                if (rst)             pc <= '0;
                else if (pc == LAST) pc <= '0;
                else                 pc <= pc + 1'b1;
            end

            assign tick = (pc == LAST);

            // R2
            tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/utmr_counter.sv
module utmr_counter #(
    parameter int          TS_W      = 64,
    parameter logic [63:0] RESET_VAL = 64'd0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            rd_lo,
    output logic [TS_W-1:0] value,
    output logic [31:0]     hi_snap
);
    localparam int HI_W = TS_W - 32;

    always_ff @(posedge clk) begin
        if (rst)       value <= TS_W'(RESET_VAL);
        else if (tick) value <= value + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)        hi_snap <= '0;
        else if (rd_lo) hi_snap <= 32'(value[TS_W-1:32]);
    end

    // R2
    ts_step_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> value == $past(value) + 1'b1);

    // R2
    ts_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(value));

    // R3
    hi_capture_chk: assert property (@(posedge clk) disable iff (rst)
        rd_lo |=> hi_snap[HI_W-1:0] == $past(value[TS_W-1:32]));
endmodule

// File: rtl/utmr_compare.sv
module utmr_compare
    import usec_tmr_pkg::*;
#(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TS_W-1:0] count,
    input  logic [1:0]      wr_cmp,
    input  logic            wr_ctrl,
    input  logic            wr_stat,
    input  logic [31:0]     wdata,
    output logic [TS_W-1:0] cmp_val,
    output logic            en,
    output logic            flag,
    output logic            irq
);
    localparam int NWORD = TS_W / 32;

    logic hit, clr;

    generate
        for (genvar w = 0; w < NWORD; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst)            cmp_val[w*32 +: 32] <= '0;
                else if (wr_cmp[w]) cmp_val[w*32 +: 32] <= wdata;
            end

            // R4
            cmp_load_chk: assert property (@(posedge clk) disable iff (rst)
                wr_cmp[w] |=> cmp_val[w*32 +: 32] == $past(wdata));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)                               en <= 1'b0;
        else if (wr_ctrl && wdata[CTRL_WEN_BIT]) en <= wdata[CTRL_EN_BIT];
    end

    assign hit = en && (count >= cmp_val);
    assign clr = wr_stat && wdata[STAT_HIT_BIT];

    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= hit || (flag && !clr);
    end

    assign irq = flag && en;

    // R5
    ctrl_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !wdata[CTRL_WEN_BIT]) |=> $stable(en));

    // R6 R9
    match_set_chk: assert property (@(posedge clk) disable iff (rst)
        (en && count >= cmp_val) |=> flag);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !(wr_stat && wdata[STAT_HIT_BIT])) |=> flag);

    // R6
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (!flag && !(en && count >= cmp_val)) |=> !flag);
endmodule

// File: rtl/usec_match_timer.sv
module usec_match_timer
    import usec_tmr_pkg::*;
#(
    parameter int          CORE_MHZ    = 100,
    parameter int          ADDR_W      = 8,
    parameter logic [63:0] RESET_COUNT = 64'd0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    output logic              bus_ready,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              irq
);
    bus_op_t          op;
    logic             tick;
    logic [TS_W-1:0]  ts;
    logic [31:0]      hi_snap;
    logic [TS_W-1:0]  cmp_val;
    logic             cmp_en, hit_flag;
    logic [1:0]       wr_cmp;
    logic [31:0]      rd_mux;

    assign bus_ready = 1'b1;

    always_comb begin
        op.sel = decode_offset(32'(bus_addr));
        op.rd  = bus_valid && !bus_write;
        op.wr  = bus_valid &&  bus_write;
    end

    assign wr_cmp[0] = op.wr && (op.sel == SEL_CMP_LO);
    assign wr_cmp[1] = op.wr && (op.sel == SEL_CMP_HI);

    utmr_prescaler #(.DIV(CORE_MHZ)) u_pre (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    utmr_counter #(.TS_W(TS_W), .RESET_VAL(RESET_COUNT)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .rd_lo  (op.rd && (op.sel == SEL_TS_LO)),
        .value  (ts),
        .hi_snap(hi_snap)
    );

    utmr_compare #(.TS_W(TS_W)) u_cmp (
        .clk    (clk),
        .rst    (rst),
        .count  (ts),
        .wr_cmp (wr_cmp),
        .wr_ctrl(op.wr && (op.sel == SEL_CTRL)),
        .wr_stat(op.wr && (op.sel == SEL_STAT)),
        .wdata  (bus_wdata),
        .cmp_val(cmp_val),
        .en     (cmp_en),
        .flag   (hit_flag),
        .irq    (irq)
    );

    always_comb begin
        rd_mux = '0;
        case (op.sel)
            SEL_TS_LO:  rd_mux = ts[31:0];
            SEL_TS_HI:  rd_mux = hi_snap;
            SEL_CMP_LO: rd_mux = cmp_val[31:0];
            SEL_CMP_HI: rd_mux = cmp_val[63:32];
            SEL_CTRL:   rd_mux[CTRL_EN_BIT]  = cmp_en;
            SEL_STAT:   rd_mux[STAT_HIT_BIT] = hit_flag;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= op.rd;
            if (op.rd) bus_rdata <= rd_mux;
        end
    end

    // R11
    read_resp_chk: assert property (@(posedge clk) disable iff (rst)
        op.rd |=> bus_rvalid);

    // R10
    hole_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op.rd && op.sel == SEL_NONE) |=> bus_rdata == 32'd0);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cmp_en && hit_flag));
endmodule

// File: tb/test_usec_match_timer.sv
module test_usec_match_timer;
    localparam int          M   = 4;
    localparam logic [63:0] RST = 64'hFFFF_FFFF_FFFF_FF80;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_ready;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        irq;

    int errors = 0;
    int checks = 0;
    longint unsigned ncyc = 0;

    always #5 clk = ~clk;

    usec_match_timer #(.CORE_MHZ(M), .ADDR_W(8), .RESET_COUNT(RST)) i_usec_match_timer (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq)
    );

    always @(posedge clk) begin
        if (rst) ncyc <= 0;
        else     ncyc <= ncyc + 1;
    end

    function automatic logic [63:0] model(input longint unsigned k);
        return RST + 64'(k / M);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge with read data sampled.
    task automatic bus_op(input bit wr, input logic [7:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output longint unsigned k);
        bus_valid = 1'b1;
        bus_write = wr;
        bus_addr  = a;
        bus_wdata = d;
        k = ncyc;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
        rd = bus_rdata;
        if (!wr) chk("R11 rvalid", 64'(bus_rvalid), 64'd1);
    endtask

    // row: {wr, addr, wdata, expected, requirement}
    localparam int NV = 21;
    localparam logic [80:0] VEC [NV] = '{
        {1'b1, 8'h08, 32'h1234_5678, 32'h0,          8'd4},  // R4
        {1'b0, 8'h08, 32'h0,         32'h1234_5678, 8'd4},  // R4
        {1'b1, 8'h0C, 32'hCAFE_0001, 32'h0,          8'd4},  // R4
        {1'b0, 8'h0C, 32'h0,         32'hCAFE_0001, 8'd4},  // R4
        {1'b1, 8'h10, 32'h0000_0001, 32'h0,          8'd5},  // R5 no write-enable
        {1'b0, 8'h10, 32'h0,         32'h0,          8'd5},  // R5
        {1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0,          8'd5},  // R5 enable, other bits read 0
        {1'b0, 8'h10, 32'h0,         32'h1,          8'd5},  // R5
        {1'b1, 8'h10, 32'h0,         32'h0,          8'd5},  // R5 no write-enable
        {1'b0, 8'h10, 32'h0,         32'h1,          8'd5},  // R5
        {1'b1, 8'h10, 32'h0000_0002, 32'h0,          8'd5},  // R5 disable
        {1'b0, 8'h10, 32'h0,         32'h0,          8'd5},  // R5
        {1'b1, 8'h18, 32'hFFFF_FFFF, 32'h0,          8'd10}, // R10
        {1'b0, 8'h18, 32'h0,         32'h0,          8'd10}, // R10
        {1'b0, 8'h1E, 32'h0,         32'h0,          8'd10}, // R10 misaligned
        {1'b0, 8'h08, 32'h0,         32'h1234_5678, 8'd10}, // R10 no alias
        {1'b0, 8'h14, 32'h0,         32'h1,          8'd6},  // R6 count above target while enabled
        {1'b1, 8'h14, 32'h0,         32'h0,          8'd7},  // R7 write 0
        {1'b0, 8'h14, 32'h0,         32'h1,          8'd7},  // R7
        {1'b1, 8'h14, 32'h1,         32'h0,          8'd7},  // R7 clear
        {1'b0, 8'h14, 32'h0,         32'h0,          8'd7}   // R7
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        longint unsigned k;
        logic [63:0] target;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", 64'(irq), 64'd0);
        chk("R1 rvalid", 64'(bus_rvalid), 64'd0);
        chk("R11 ready", 64'(bus_ready), 64'd1);
        bus_op(1'b0, 8'h00, 32'h0, rd, k);
        chk("R1 ts_lo", 64'(rd), 64'(model(k) & 64'hFFFF_FFFF));
        chk("R1 ts_lo start", 64'(rd), 64'h0000_0000_FFFF_FF80);
        bus_op(1'b0, 8'h04, 32'h0, rd, k);
        chk("R1 ts_hi", 64'(rd), 64'hFFFF_FFFF);
        bus_op(1'b0, 8'h08, 32'h0, rd, k); chk("R1 cmp_lo", 64'(rd), 64'd0);
        bus_op(1'b0, 8'h0C, 32'h0, rd, k); chk("R1 cmp_hi", 64'(rd), 64'd0);
        bus_op(1'b0, 8'h10, 32'h0, rd, k); chk("R1 ctrl", 64'(rd), 64'd0);
        bus_op(1'b0, 8'h14, 32'h0, rd, k); chk("R1 stat", 64'(rd), 64'd0);

        for (int i = 0; i < NV; i++) begin
            bus_op(VEC[i][80], VEC[i][79:72], VEC[i][71:40], rd, k);
            if (!VEC[i][80])
                chk($sformatf("R%0d row %0d", VEC[i][7:0], i), 64'(rd), 64'(VEC[i][39:8]));
        end

        // R10: writes to the counter words are ignored
        bus_op(1'b1, 8'h00, 32'h0, rd, k);
        bus_op(1'b1, 8'h04, 32'h0, rd, k);
        bus_op(1'b0, 8'h00, 32'h0, rd, k);
        chk("R10 ts_lo ro", 64'(rd), model(k) & 64'hFFFF_FFFF);
        chk("R2 before carry", 64'(k < 512), 64'd1);

        // R3: carry into the upper word after the low read; high read keeps snapshot
        while (ncyc < 530) @(negedge clk);
        bus_op(1'b0, 8'h04, 32'h0, rd, k);
        chk("R3 coherent hi", 64'(rd), 64'hFFFF_FFFF);

        // R2: wrap to zero, fresh pair
        bus_op(1'b0, 8'h00, 32'h0, rd, k);
        chk("R2 wrapped lo", 64'(rd), model(k) & 64'hFFFF_FFFF);
        bus_op(1'b0, 8'h04, 32'h0, rd, k);
        chk("R2 wrapped hi", 64'(rd), 64'd0);
        chk("R3 snapshot refresh", 64'(rd), model(k - 1) >> 32);

        // R6/R8: program target 100 ticks ahead
        bus_op(1'b0, 8'h00, 32'h0, rd, k);
        target = model(k) + 64'd100;
        bus_op(1'b1, 8'h0C, target[63:32], rd, k);
        bus_op(1'b1, 8'h08, target[31:0], rd, k);
        bus_op(1'b1, 8'h10, 32'h3, rd, k);
        chk("R8 irq before match", 64'(irq), 64'd0);
        while (model(ncyc) != target) @(negedge clk);
        chk("R6 not early", 64'(irq), 64'd0);
        @(negedge clk);
        chk("R8 irq at match", 64'(irq), 64'd1);
        bus_op(1'b0, 8'h14, 32'h0, rd, k);
        chk("R6 stat", 64'(rd), 64'd1);

        // R9: clear while the match is still live
        bus_op(1'b1, 8'h14, 32'h1, rd, k);
        chk("R9 irq held", 64'(irq), 64'd1);
        bus_op(1'b0, 8'h14, 32'h0, rd, k);
        chk("R9 stat held", 64'(rd), 64'd1);

        // R7/R8: disable keeps the flag but masks irq
        bus_op(1'b1, 8'h10, 32'h2, rd, k);
        chk("R8 irq masked", 64'(irq), 64'd0);
        bus_op(1'b0, 8'h14, 32'h0, rd, k);
        chk("R7 survives disable", 64'(rd), 64'd1);
        bus_op(1'b1, 8'h14, 32'h1, rd, k);
        bus_op(1'b0, 8'h14, 32'h0, rd, k);
        chk("R7 cleared", 64'(rd), 64'd0);

        // R5: enable without write-enable has no effect
        bus_op(1'b1, 8'h10, 32'h1, rd, k);
        @(negedge clk);
        chk("R5 irq stays low", 64'(irq), 64'd0);
        bus_op(1'b0, 8'h14, 32'h0, rd, k);
        chk("R5 no match", 64'(rd), 64'd0);
        bus_op(1'b0, 8'h10, 32'h0, rd, k);
        chk("R5 ctrl", 64'(rd), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule